// File: doc/BRIEF.md
# MII Management Frame Controller

This block runs one MII management transaction on an MDC/MDIO pair each time the host writes a frame word. The host sees two 32-bit registers through a simple write-strobe bus: a configuration register that selects frame mode and picks one of two transceiver ports, and a frame register that holds the management frame to send. A write to the frame register, made while the controller is idle and in frame mode, starts a frame. The controller sends a preamble of 32 ones. It then shifts out the start, opcode, PHY address and register address fields. After that it drives the turnaround and data for a write, or releases the line and captures sixteen data bits for a read.

Completion is reported in the frame register itself. The controller sets the low turnaround bit when the frame ends, and the host polls that bit. On a read, the captured data replaces the low sixteen bits of the register at that moment. The MDC rate is set by a parameter that gives the number of system clocks in each half period of MDC. Port 0 is the internal transceiver and port 1 is the external one. The level on the port 1 data line is also reported as a presence flag for an external transceiver.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, both registers read zero (apart from the presence flag, bit 2 of the configuration register), MDC is low on both ports, and neither port drives MDIO.
- R2: The bus address selects the register: 0 for configuration, 1 for the frame register. A frame-register write made while the controller is idle and in frame mode starts a frame. That write clears bit 16, the completion bit, at once. The frame on the line is 32 ones followed by word bits 31:18, most significant bit first. Bit 16 becomes 1 when the frame ends.
- R3: A write frame (word bits 29:28 = 01) drives turnaround bits 1 then 0 and then word bits 15:0, MSB first. This gives exactly 64 MDC rising edges per frame.
- R4: A read frame (word bits 29:28 = 10) stops driving MDIO from the first turnaround bit to the end of the frame. It captures the sixteen bits present at the last sixteen MDC rising edges. When bit 16 is set, the captured bits appear in bits 15:0 of the frame register, and bits 31:17 keep the values the host wrote.
- R5: The MDC period is 2*MDC_HALF system clocks. MDIO output changes only while MDC is low.
- R6: Configuration bit 1 selects port 0 (clear) or port 1 (set). The unselected port keeps MDC low and MDIO undriven. The selection is captured when a frame starts, and later changes to bit 1 do not affect that frame.
- R7: With configuration bit 0 (bit-bang mode) set, a frame-register write stores the word with bit 16 clear but starts no frame. No MDC edges occur.
- R8: A frame-register write that arrives while a frame is in progress is ignored. The register contents, the frame on the line and the number of frames sent do not change.
- R9: Configuration bit 2 reads the port 1 MDIO line level through a two-stage synchronizer. Host writes to bit 2 have no effect.
- R10: Between frames, MDC is low and MDIO is undriven on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 configuration, 1 frame |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data of the register chosen by bus_addr |
| mdc | output | 2 | Management clock per port (bit 0 internal, bit 1 external) |
| mdio_o | output | 2 | MDIO output value per port |
| mdio_oe | output | 2 | MDIO output enable per port |
| mdio_i | input | 2 | MDIO line level per port |

## Verification
A wrong bit index or a wrong frame length inside the shifter shows up on the first frame. It appears as a wrong pattern in the 64 bits captured on the selected port, or as a count of MDC rising edges other than 64, and it is visible within about 128*MDC_HALF cycles of the start write. A latch of the wrong port, or a missed hold while busy, shows in the next frame as MDC edges on the idle port or as an extra frame. A fault in the read capture or the completion path is only seen when the host reads the frame register after the completion bit sets. For that reason every scenario reads that register back and compares all 32 bits.

// File: rtl/mdio_frame_pkg.sv
// Shared types and constants for the MII management frame controller.
// Assumes a two-port configuration and a 32-bit host word.
package mdio_frame_pkg;

    localparam int PORTS       = 2;
    localparam int PREAMBLE    = 32;
    localparam int FRAME_BITS  = 64;
    localparam int TA_FIRST    = 46;
    localparam int DATA_FIRST  = 48;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int WORD_IDX_W  = $clog2(PREAMBLE);
    localparam int PORT_EXT    = 1;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic       ADDR_CFG   = 1'b0;
    localparam logic       ADDR_FRAME = 1'b1;

    // Host frame word, MSB first matches line order after the preamble.
    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic        ta_hi;
        logic        ta_lo;
        logic [15:0] data;
    } frame_t;

    // Configuration register layout.
    typedef struct packed {
        logic [28:0] rsvd;
        logic        ext_seen;
        logic        port_sel;
        logic        bitbang;
    } cfg_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC divider: while run is high, toggles mdc every MDC_HALF system clocks.
// rise/fall mark the cycle in which mdc changes. Assumes MDC_HALF >= 1.
module mdio_mdc_gen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MDC_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             terminal;

    assign terminal = run && (cnt_q == CNT_LAST);
    assign rise     = terminal && !mdc_q;
    assign fall     = terminal && mdc_q;
    assign mdc      = mdc_q;

    // Half-period counter and clock level; parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame shifter: on start, latches the frame word and port, then emits
// preamble and frame bit by bit, advancing on MDC falling edges and
// sampling read data on rising edges. Assumes start only when idle.
module mdio_frame_engine
    import mdio_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  frame_t      frame_in,
    input  logic        port_in,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done_pulse,
    output logic [15:0] rd_word,
    output logic        port_q,
    output logic        mdio_out,
    output logic        mdio_en
);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA    = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] IDX_FRAME = IDX_W'(PREAMBLE);

    frame_t           hdr_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic             done_q;
    logic [15:0]      shift_q;
    logic             port_r;
    logic [31:0]      tx_word;
    logic [IDX_W-1:0] rev_idx;
    logic             is_read;

    assign is_read = (hdr_q.op == OP_READ);
    assign tx_word = {hdr_q.st, hdr_q.op, hdr_q.phy, hdr_q.regad, 2'b10, hdr_q.data};
    assign rev_idx = IDX_LAST - idx_q;

    // Line bit for the current index: ones in the preamble, then the word.
    always_comb begin
        if (idx_q < IDX_FRAME) mdio_out = busy_q;
        else                   mdio_out = busy_q && tx_word[rev_idx[WORD_IDX_W-1:0]];
    end

    // Drive everywhere except turnaround and data of a read.
    assign mdio_en = busy_q && !(is_read && (idx_q >= IDX_TA));

    // Sequencing of bit index, busy and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            hdr_q  <= '0;
            port_r <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                hdr_q  <= frame_in;
                port_r <= port_in;
            end else if (busy_q && fall) begin
                if (idx_q == IDX_LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Capture read data on MDC rising edges within the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (busy_q && rise && is_read && (idx_q >= IDX_DATA)) begin
            shift_q <= {shift_q[14:0], mdio_in};
        end
    end

    assign busy       = busy_q;
    assign done_pulse = done_q;
    assign rd_word    = shift_q;
    assign port_q     = port_r;
endmodule

// File: rtl/mdio_host_regs.sv
// Host-visible configuration and frame registers. Accepts a frame write
// only when idle; issues a one-cycle start when in frame mode; records
// completion and read data. Assumes single-cycle write strobes.
module mdio_host_regs
    import mdio_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_line,
    input  logic        eng_busy,
    input  logic        done_pulse,
    input  logic [15:0] rd_word,
    output frame_t      frame_q,
    output logic        port_sel,
    output logic        start
);
    cfg_t       cfg_view;
    logic       bitbang_q;
    logic       port_q;
    logic [1:0] ext_sync_q;
    logic       start_q;
    logic       hold;
    logic       accept;
    frame_t     wr_frame;

    assign wr_frame = frame_t'(bus_wdata);
    assign hold     = eng_busy || start_q || done_pulse;
    assign accept   = bus_wr && (bus_addr == ADDR_FRAME) && !hold;

    // Frame register: host load, then completion flag and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (accept) begin
            frame_q       <= wr_frame;
            frame_q.ta_lo <= 1'b0;
        end else if (done_pulse) begin
            frame_q.ta_lo <= 1'b1;
            if (frame_q.op == OP_READ) frame_q.data <= rd_word;
        end
    end

    // Start request, one cycle after an accepted write in frame mode.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= accept && !bitbang_q;
    end

    // Writable configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitbang_q <= 1'b0;
            port_q    <= 1'b0;
        end else if (bus_wr && (bus_addr == ADDR_CFG)) begin
            bitbang_q <= bus_wdata[0];
            port_q    <= bus_wdata[1];
        end
    end

    // Two-stage synchronizer for the external presence line.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync_q <= '0;
        else        ext_sync_q <= {ext_sync_q[0], ext_line};
    end

    always_comb begin
        cfg_view          = '0;
        cfg_view.bitbang  = bitbang_q;
        cfg_view.port_sel = port_q;
        cfg_view.ext_seen = ext_sync_q[1];
    end

    // Read mux.
    assign bus_rdata = (bus_addr == ADDR_FRAME) ? 32'(frame_q) : 32'(cfg_view);
    assign port_sel  = port_q;
    assign start     = start_q;
endmodule

// File: rtl/mdio_port_route.sv
// Routes the single engine to one of PORTS transceiver pins; unselected
// ports are held quiet. Assumes port_sel < PORTS.
module mdio_port_route
    import mdio_frame_pkg::*;
(
    input  logic             port_sel,
    input  logic             mdc_in,
    input  logic             mdo_in,
    input  logic             oe_in,
    input  logic [PORTS-1:0] mdi_pins,
    output logic [PORTS-1:0] mdc_pins,
    output logic [PORTS-1:0] mdo_pins,
    output logic [PORTS-1:0] oe_pins,
    output logic             mdi_out
);
    for (genvar g = 0; g < PORTS; g++) begin : g_port
        logic hit;
        assign hit         = (int'(port_sel) == g);
        assign mdc_pins[g] = hit && mdc_in;
        assign mdo_pins[g] = hit && mdo_in;
        assign oe_pins[g]  = hit && oe_in;
    end

    assign mdi_out = mdi_pins[port_sel];
endmodule

// File: rtl/mdio_frame_ctrl.sv
// Top of the MII management frame controller: host registers, MDC divider,
// frame shifter and port routing. Assumes MDIO pins are resolved outside.
module mdio_frame_ctrl
    import mdio_frame_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [PORTS-1:0] mdc,
    output logic [PORTS-1:0] mdio_o,
    output logic [PORTS-1:0] mdio_oe,
    input  logic [PORTS-1:0] mdio_i
);
    frame_t      frame_w;
    logic [31:0] frame_bits;
    logic        port_cfg;
    logic        start_w;
    logic        eng_busy;
    logic        done_w;
    logic [15:0] rd_w;
    logic        port_act;
    logic        mdo_w;
    logic        oe_w;
    logic        mdc_w;
    logic        rise_w;
    logic        fall_w;
    logic        mdi_w;

    assign frame_bits = 32'(frame_w);

    mdio_host_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_line   (mdio_i[PORT_EXT]),
        .eng_busy   (eng_busy),
        .done_pulse (done_w),
        .rd_word    (rd_w),
        .frame_q    (frame_w),
        .port_sel   (port_cfg),
        .start      (start_w)
    );

    mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) mdc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .mdc   (mdc_w),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    mdio_frame_engine eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .frame_in   (frame_w),
        .port_in    (port_cfg),
        .rise       (rise_w),
        .fall       (fall_w),
        .mdio_in    (mdi_w),
        .busy       (eng_busy),
        .done_pulse (done_w),
        .rd_word    (rd_w),
        .port_q     (port_act),
        .mdio_out   (mdo_w),
        .mdio_en    (oe_w)
    );

    mdio_port_route route_i (
        .port_sel (port_act),
        .mdc_in   (mdc_w),
        .mdo_in   (mdo_w),
        .oe_in    (oe_w),
        .mdi_pins (mdio_i),
        .mdc_pins (mdc),
        .mdo_pins (mdio_o),
        .oe_pins  (mdio_oe),
        .mdi_out  (mdi_w)
    );
endmodule

// File: rtl/mdio_frame_chk.sv
// Protocol checker for mdio_frame_ctrl, attached by bind below.
module mdio_frame_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mdc,
    input logic [1:0]  mdio_o,
    input logic [1:0]  mdio_oe,
    input logic        busy,
    input logic        done_bit,
    input logic [15:0] frame_hdr
);
    // R5
    mdio_hold_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc[0] && $past(mdc[0])) |-> $stable(mdio_o[0]));
    // R5
    mdio_hold_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc[1] && $past(mdc[1])) |-> $stable(mdio_o[1]));
    // R6
    single_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdc));
    // R6
    single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdio_oe));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdc == 2'b00 && mdio_oe == 2'b00));
    // R2
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_bit) |-> $past(busy, 2));
    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(frame_hdr));
endmodule

bind mdio_frame_ctrl mdio_frame_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (eng_busy),
    .done_bit  (frame_bits[16]),
    .frame_hdr (frame_bits[31:16])
);

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  mdc;
    logic [1:0]  mdio_o;
    logic [1:0]  mdio_oe;
    wire  [1:0]  line;

    int          checks = 0;
    int          failures = 0;
    int          base [2];
    logic        phy_rd = 1'b0;
    logic [15:0] resp = '0;
    logic        ext_pull = 1'b1;

    always #5 clk = ~clk;

    mdio_frame_ctrl #(.MDC_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
    );

    // PHY model per port: captures bits on MDC rise, answers reads after fall.
    for (genvar g = 0; g < 2; g++) begin : phy
        int          rises = 0;
        int          clash = 0;
        logic [63:0] cap = '0;
        logic        drv = 1'b0;
        logic        val = 1'b0;
        longint      last_t = 0;
        longint      period = 0;
        logic        pull;
        assign pull    = (g == 0) ? 1'b1 : ext_pull;
        assign line[g] = mdio_oe[g] ? mdio_o[g] : (drv ? val : pull);

        always @(posedge mdc[g]) begin
            cap    = {cap[62:0], line[g]};
            rises  = rises + 1;
            period = longint'($time) - last_t;
            last_t = longint'($time);
        end

        always @(negedge mdc[g]) begin
            int idx;
            idx = rises - base[g];
            if (phy_rd && idx == 47) begin
                drv = 1'b1; val = 1'b0;
            end else if (phy_rd && idx >= 48 && idx <= 63) begin
                drv = 1'b1; val = resp[63-idx];
            end else begin
                drv = 1'b0;
            end
        end

        always @(posedge clk) if (mdio_oe[g] && drv) clash = clash + 1;
    end

    function automatic int get_rises(input int p);
        return (p == 0) ? phy[0].rises : phy[1].rises;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(1'b1, v);
            if (v[16]) begin ok = 1'b1; break; end
        end
    endtask

    function automatic logic [31:0] mk_word(input logic rd, input logic [4:0] ph, input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), ph, ra, 2'b10, (rd ? 16'h0 : d)};
    endfunction

    // Full frame on port p, with line, count, port and readback checks.
    task automatic run_frame(input int p, input logic rd, input logic [4:0] ph, input logic [4:0] ra,
                             input logic [15:0] d, input logic [15:0] rsp);
        logic [31:0] w, v;
        logic [15:0] dexp;
        bit ok;
        w = mk_word(rd, ph, ra, d);
        bus_write(1'b0, {30'b0, p[0], 1'b0});
        base[0] = get_rises(0); base[1] = get_rises(1);
        phy_rd = rd; resp = rsp;
        bus_write(1'b1, w);
        bus_read(1'b1, v);
        check(v[16] == 1'b0, "R2 completion bit cleared by write", 64'(v[16]), 64'(0));
        wait_done(ok);
        check(ok, "R2 completion bit set", 64'(ok), 64'(1));
        check(get_rises(p) - base[p] == 64, "R3 64 MDC edges", 64'(get_rises(p) - base[p]), 64'(64));
        check(get_rises(1-p) - base[1-p] == 0, "R6 idle port quiet", 64'(get_rises(1-p) - base[1-p]), 64'(0));
        dexp = rd ? rsp : d;
        if (p == 0)
            check(phy[0].cap == {32'hFFFF_FFFF, w[31:18], 2'b10, dexp}, rd ? "R4 read line bits" : "R3 write line bits",
                  phy[0].cap, {32'hFFFF_FFFF, w[31:18], 2'b10, dexp});
        else
            check(phy[1].cap == {32'hFFFF_FFFF, w[31:18], 2'b10, dexp}, "R6 port1 line bits",
                  phy[1].cap, {32'hFFFF_FFFF, w[31:18], 2'b10, dexp});
        bus_read(1'b1, v);
        check(v == {w[31:17], 1'b1, dexp}, rd ? "R4 read data in register" : "R2 register after write",
              64'(v), 64'({w[31:17], 1'b1, dexp}));
        check(phy[0].clash + phy[1].clash == 0, "R4 no contention in turnaround",
              64'(phy[0].clash + phy[1].clash), 64'(0));
        phy_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (4) @(negedge clk);
        check(mdc == 2'b00 && mdio_oe == 2'b00, "R1 pins quiet after reset", 64'({mdc, mdio_oe}), 64'(0));
        bus_read(1'b1, v);
        check(v == 32'h0, "R1 frame register reset", 64'(v), 64'(0));
        bus_read(1'b0, v);
        check(v == 32'h4, "R1 config reset with presence", 64'(v), 64'(4));
    endtask

    task automatic t_period();
        run_frame(0, 1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0);
        check(phy[0].period == longint'(2*HALF*10), "R5 MDC period", 64'(phy[0].period), 64'(2*HALF*10));
        repeat (20) @(negedge clk);
        check(mdc == 2'b00 && mdio_oe == 2'b00, "R10 idle between frames", 64'({mdc, mdio_oe}), 64'(0));
    endtask

    task automatic t_bitbang();
        logic [31:0] v, w;
        int r0, r1;
        w = mk_word(1'b0, 5'h02, 5'h03, 16'h1234);
        bus_write(1'b0, 32'h1);
        r0 = get_rises(0); r1 = get_rises(1);
        bus_write(1'b1, w);
        repeat (500) @(negedge clk);
        check(get_rises(0) == r0 && get_rises(1) == r1, "R7 no MDC in bit-bang mode",
              64'(get_rises(0) - r0 + get_rises(1) - r1), 64'(0));
        bus_read(1'b1, v);
        check(v == {w[31:17], 1'b0, w[15:0]}, "R7 word stored, not complete", 64'(v), 64'({w[31:17], 1'b0, w[15:0]}));
        bus_write(1'b0, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] a, b, v;
        bit ok;
        a = mk_word(1'b0, 5'h07, 5'h11, 16'h0F0F);
        b = mk_word(1'b1, 5'h1F, 5'h1F, 16'h0);
        base[0] = get_rises(0);
        bus_write(1'b1, a);
        repeat (100) @(negedge clk);
        bus_write(1'b1, b);
        wait_done(ok);
        repeat (500) @(negedge clk);
        check(get_rises(0) - base[0] == 64, "R8 single frame despite second write",
              64'(get_rises(0) - base[0]), 64'(64));
        check(phy[0].cap == {32'hFFFF_FFFF, a[31:18], 2'b10, a[15:0]}, "R8 line carries first word",
              phy[0].cap, {32'hFFFF_FFFF, a[31:18], 2'b10, a[15:0]});
        bus_read(1'b1, v);
        check(v == {a[31:17], 1'b1, a[15:0]}, "R8 register keeps first word", 64'(v), 64'({a[31:17], 1'b1, a[15:0]}));
    endtask

    task automatic t_port_latch();
        bit ok;
        base[0] = get_rises(0); base[1] = get_rises(1);
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, mk_word(1'b0, 5'h04, 5'h05, 16'h8001));
        repeat (100) @(negedge clk);
        bus_write(1'b0, 32'h2);
        wait_done(ok);
        check(get_rises(0) - base[0] == 64 && get_rises(1) == base[1], "R6 port latched at start",
              64'(get_rises(1) - base[1]), 64'(0));
        bus_write(1'b0, 32'h0);
    endtask

    task automatic t_presence();
        logic [31:0] v;
        ext_pull = 1'b0;
        repeat (5) @(negedge clk);
        bus_write(1'b0, 32'h4);
        bus_read(1'b0, v);
        check(v[2] == 1'b0, "R9 presence low, write ignored", 64'(v), 64'(0));
        ext_pull = 1'b1;
        repeat (5) @(negedge clk);
        bus_read(1'b0, v);
        check(v[2] == 1'b1, "R9 presence high", 64'(v[2]), 64'(1));
        bus_write(1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        run_frame(0, 1'b1, 5'h00, 5'h01, 16'h0, 16'h796D);
        run_frame(1, 1'b0, 5'h1F, 5'h1E, 16'hFFFF, 16'h0);
        run_frame(1, 1'b1, 5'h15, 5'h0A, 16'h0, 16'h0001);
        run_frame(0, 1'b1, 5'h0A, 5'h15, 16'h0, 16'hFFFE);
        t_bitbang();
        t_busy_ignore();
        t_port_latch();
        t_presence();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule